// File: doc/BRIEF.md
# Receive Frame Queue with DMA Handshake

This block is a small first-in first-out store that sits between a CAN frame-reception engine and a memory-mapped read window. Each time the reception engine finishes a frame it presents the identifier, the control word, two data words and the index of the acceptance filter that matched, with a one-cycle valid strobe. The queue keeps up to six such frames. The oldest one is always visible through a four-word output window and an attribute register.

Software or a DMA channel drains the queue through a simple bus. Reading the last word of the output window removes the oldest frame. A frames-available flag tells the consumer that the window holds a frame. In DMA mode a request line follows that flag, and the flag drops for one cycle after each removal so that every frame produces a distinct request. In interrupt mode the block also keeps a sticky almost-full warning and a sticky overflow flag. These flags are cleared by writing one to them, and they feed a maskable interrupt line.

The bus map uses byte offsets. Offset 0x30 is the flag register, 0x34 the interrupt-enable register and 0x38 the attribute register. The output window is 0x80 for the control word, 0x84 for the identifier, 0x88 for data word 0 and 0x8C for data word 1. Bus reads are combinational from the current state. All updates take effect at the rising clock edge on which the strobe is sampled.

Top module: `can_rxq`

## Requirements
- R1: The queue stores at most six frames and returns them oldest first. A frame that arrives while six are stored, with no removal in the same cycle, is discarded.
- R2: While a frame is stored, the window returns its words: control at 0x80, identifier at 0x84, data 0 at 0x88 and data 1 at 0x8C. Offset 0x38 returns its filter-hit index in bits 8:0. While the queue is empty, all five offsets read zero.
- R3: Flag bit 0 (frames available) is set at the clock edge that stores a frame into an empty queue, and it is never set while the queue is empty.
- R4: With `dma_mode` high, `dma_req` is high in exactly the cycles in which flag bit 0 is high. With `dma_mode` low, `dma_req` stays low.
- R5: A read of offset 0x8C with a frame stored removes the oldest frame at that edge. In the following cycle flag bit 0 and `dma_req` are low, and the window and attribute show the next frame. One cycle later both are high again if frames remain. If the queue is now empty they stay low.
- R6: In interrupt mode, flag bit 1 (warning) is set at the edge where the occupancy goes from below five to five or more. It stays set after the queue drains, until software clears it.
- R7: In interrupt mode, flag bit 2 (overflow) is set when a frame is discarded because the queue is full.
- R8: While `dma_mode` is high, flag bits 1 and 2 are never set.
- R9: Writing one to flag bit 1 or bit 2 at 0x30 clears that bit, and writing zero leaves it unchanged. In interrupt mode, writing one to bit 0 removes the oldest frame, as the 0x8C read does. In DMA mode, writing one to bit 0 has no effect on the flag or on the queue.
- R10: `irq` is the OR of the flag bits whose enable is set in the same bit position at 0x34. It is forced low while `dma_mode` is high.
- R11: A new frame and a removal in the same cycle leave the occupancy unchanged, also when the queue is full. Neither frame is lost, and no overflow is recorded.
- R12: An active-low asynchronous reset empties the queue and clears all flags and enables. `dma_req` and `irq` go low at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_mode | input | 1 | 1 selects DMA draining, 0 selects interrupt draining |
| rx_valid | input | 1 | One-cycle strobe: a completed frame is presented |
| rx_id | input | 32 | Identifier word of the presented frame |
| rx_ctrl | input | 32 | Control word (length, flags, time stamp) |
| rx_data0 | input | 32 | First data word |
| rx_data1 | input | 32 | Second data word |
| rx_hit | input | 9 | Index of the acceptance filter that matched |
| bus_rd | input | 1 | Bus read strobe, one cycle per access |
| bus_wr | input | 1 | Bus write strobe, one cycle per access |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for the current offset |
| dma_req | output | 1 | DMA request, mirrors frames available in DMA mode |
| irq | output | 1 | Interrupt request, interrupt mode only |

## Verification
Every stored result changes on the rising edge that samples the strobe. The bench drives each strobe just after a falling edge and reads the result at the next falling edge. Read data is combinational, so it is sampled one time unit after the address is driven, before the edge that may remove the frame. The one-cycle gap in the frames-available flag after a removal is checked at the falling edge straight after the removal edge, and its return is checked one full clock later. The asynchronous reset is checked between edges.

// File: rtl/can_rxq_pkg.sv
package can_rxq_pkg;

  localparam int WORD_W = 32;
  localparam int HIT_W  = 9;
  localparam int ADDR_W = 8;
  localparam int NFLAG  = 3;

  // flag bit positions, shared by the flag and enable registers
  localparam int FLG_AVAIL = 0;
  localparam int FLG_WARN  = 1;
  localparam int FLG_OVF   = 2;

  // byte offsets of the bus map
  localparam logic [ADDR_W-1:0] OFS_FLAGS  = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_IEN    = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_ATTR   = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_W_CTRL = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_W_ID   = 8'h84;
  localparam logic [ADDR_W-1:0] OFS_W_D0   = 8'h88;
  localparam logic [ADDR_W-1:0] OFS_W_D1   = 8'h8C; // read pops

  typedef struct packed {
    logic [WORD_W-1:0] ctrl;
    logic [WORD_W-1:0] id;
    logic [WORD_W-1:0] d0;
    logic [WORD_W-1:0] d1;
    logic [HIT_W-1:0]  hit;
  } rx_frame_t;

endpackage

// File: rtl/can_rxq_store.sv
module can_rxq_store
  import can_rxq_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  rx_frame_t        frame_i,
  input  logic             pop_i,
  output rx_frame_t        head_o,
  output logic             head_vld_o,
  output logic [CNT_W-1:0] cnt_q_o,
  output logic [CNT_W-1:0] cnt_d_o,
  output logic             pop_eff_o,
  output logic             drop_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  rx_frame_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             empty, full, push_eff, pop_eff;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CNT_FULL);
  assign pop_eff  = pop_i && !empty;
  assign push_eff = push_i && (!full || pop_eff);

  // next state
  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push_eff) wr_ptr_d = ptr_inc(wr_ptr_q);
    if (pop_eff)  rd_ptr_d = ptr_inc(rd_ptr_q);
    case ({push_eff, pop_eff})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // payload slots: no reset, written only under their own enable
  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic slot_we;
    assign slot_we = push_eff && (wr_ptr_q == PTR_W'(e));
    always_ff @(posedge clk) begin
      if (slot_we) mem[e] <= frame_i;
    end
  end

  assign head_vld_o = !empty;
  assign head_o     = empty ? '0 : mem[rd_ptr_q];
  assign cnt_q_o    = cnt_q;
  assign cnt_d_o    = cnt_d;
  assign pop_eff_o  = pop_eff;
  assign drop_o     = push_i && !push_eff;

  p_count_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

  p_full_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop_i) |=> (cnt_q == CNT_FULL));

  p_same_cycle_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !empty) |=> (cnt_q == $past(cnt_q)));

  p_one_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i) |=> $stable(cnt_q));

endmodule

// File: rtl/can_rxq_flags.sv
module can_rxq_flags
  import can_rxq_pkg::*;
#(
  parameter int DEPTH    = 6,
  parameter int WARN_LVL = 5,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dma_mode_i,
  input  logic [CNT_W-1:0] cnt_q_i,
  input  logic [CNT_W-1:0] cnt_d_i,
  input  logic             pop_eff_i,
  input  logic             drop_i,
  input  logic [1:0]       clr_i,     // [0] warning, [1] overflow
  input  logic [NFLAG-1:0] ien_i,
  output logic [NFLAG-1:0] flags_o,
  output logic             dma_req_o,
  output logic             irq_o
);

  localparam logic [CNT_W-1:0] CNT_WARN = CNT_W'(WARN_LVL);

  logic avail_q, avail_d;
  logic warn_q,  warn_d;
  logic ovf_q,   ovf_d;
  logic warn_set, ovf_set;

  assign warn_set = !dma_mode_i && (cnt_d_i >= CNT_WARN) && (cnt_q_i < CNT_WARN);
  assign ovf_set  = !dma_mode_i && drop_i;

  // next state; a set in the same cycle wins over a clear
  always_comb begin
    avail_d = (cnt_d_i != '0) && !pop_eff_i;
    warn_d  = warn_q;
    ovf_d   = ovf_q;
    if (clr_i[0]) warn_d = 1'b0;
    if (clr_i[1]) ovf_d  = 1'b0;
    if (warn_set) warn_d = 1'b1;
    if (ovf_set)  ovf_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avail_q <= 1'b0;
      warn_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      avail_q <= avail_d;
      warn_q  <= warn_d;
      ovf_q   <= ovf_d;
    end
  end

  always_comb begin
    flags_o            = '0;
    flags_o[FLG_AVAIL] = avail_q;
    flags_o[FLG_WARN]  = warn_q;
    flags_o[FLG_OVF]   = ovf_q;
  end

  assign dma_req_o = dma_mode_i && avail_q;
  assign irq_o     = !dma_mode_i && |(flags_o & ien_i);

  p_empty_no_avail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q_i == '0) |-> !avail_q);

  p_req_needs_avail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_o |-> (avail_q && dma_mode_i));

  p_pop_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_eff_i |=> !avail_q);

  p_warn_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_q && !clr_i[0]) |=> warn_q);

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_i[1]) |=> ovf_q);

  p_dma_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(warn_q) || $rose(ovf_q)) |-> !$past(dma_mode_i));

  p_irq_off_in_dma_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_mode_i |-> !irq_o);

endmodule

// File: rtl/can_rxq_regs.sv
module can_rxq_regs
  import can_rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_mode_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  input  rx_frame_t         head_i,
  input  logic              head_vld_i,
  input  logic [NFLAG-1:0]  flags_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  output logic              pop_o,
  output logic [1:0]        clr_o,
  output logic [NFLAG-1:0]  ien_o
);

  logic [NFLAG-1:0] ien_q, ien_d;
  logic             wr_flags, wr_ien, rd_pop, wr_pop;

  assign wr_flags = bus_wr_i && (bus_addr_i == OFS_FLAGS);
  assign wr_ien   = bus_wr_i && (bus_addr_i == OFS_IEN);
  assign rd_pop   = bus_rd_i && (bus_addr_i == OFS_W_D1);
  assign wr_pop   = wr_flags && bus_wdata_i[FLG_AVAIL] && !dma_mode_i;

  assign pop_o = rd_pop || wr_pop;
  assign clr_o = wr_flags ? {bus_wdata_i[FLG_OVF], bus_wdata_i[FLG_WARN]} : 2'b00;

  always_comb begin
    ien_d = ien_q;
    if (wr_ien) ien_d = bus_wdata_i[NFLAG-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ien_q <= '0;
    else        ien_q <= ien_d;
  end

  assign ien_o = ien_q;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_rd_i) begin
      case (bus_addr_i)
        OFS_FLAGS:  bus_rdata_o = WORD_W'(flags_i);
        OFS_IEN:    bus_rdata_o = WORD_W'(ien_q);
        OFS_ATTR:   bus_rdata_o = WORD_W'(head_i.hit);
        OFS_W_CTRL: bus_rdata_o = head_i.ctrl;
        OFS_W_ID:   bus_rdata_o = head_i.id;
        OFS_W_D0:   bus_rdata_o = head_i.d0;
        OFS_W_D1:   bus_rdata_o = head_i.d1;
        default:    bus_rdata_o = '0;
      endcase
    end
  end

  p_window_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!head_vld_i && bus_rd_i && (bus_addr_i[7] || bus_addr_i == OFS_ATTR))
      |-> (bus_rdata_o == '0));

  p_no_write_pop_in_dma_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_mode_i && !bus_rd_i) |-> !pop_o);

endmodule

// File: rtl/can_rxq.sv
module can_rxq
  import can_rxq_pkg::*;
#(
  parameter int DEPTH    = 6,
  parameter int WARN_LVL = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dma_mode,
  input  logic                rx_valid,
  input  logic [WORD_W-1:0]   rx_id,
  input  logic [WORD_W-1:0]   rx_ctrl,
  input  logic [WORD_W-1:0]   rx_data0,
  input  logic [WORD_W-1:0]   rx_data1,
  input  logic [HIT_W-1:0]    rx_hit,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  output logic                dma_req,
  output logic                irq
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  rx_frame_t        in_frame, head;
  logic             head_vld, pop_req, pop_eff, drop;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       clr;
  logic [NFLAG-1:0] ien, flags;

  assign in_frame.ctrl = rx_ctrl;
  assign in_frame.id   = rx_id;
  assign in_frame.d0   = rx_data0;
  assign in_frame.d1   = rx_data1;
  assign in_frame.hit  = rx_hit;

  can_rxq_store #(.DEPTH(DEPTH)) i_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (rx_valid),
    .frame_i    (in_frame),
    .pop_i      (pop_req),
    .head_o     (head),
    .head_vld_o (head_vld),
    .cnt_q_o    (cnt_q),
    .cnt_d_o    (cnt_d),
    .pop_eff_o  (pop_eff),
    .drop_o     (drop)
  );

  can_rxq_flags #(.DEPTH(DEPTH), .WARN_LVL(WARN_LVL)) i_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .dma_mode_i (dma_mode),
    .cnt_q_i    (cnt_q),
    .cnt_d_i    (cnt_d),
    .pop_eff_i  (pop_eff),
    .drop_i     (drop),
    .clr_i      (clr),
    .ien_i      (ien),
    .flags_o    (flags),
    .dma_req_o  (dma_req),
    .irq_o      (irq)
  );

  can_rxq_regs i_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .dma_mode_i  (dma_mode),
    .bus_rd_i    (bus_rd),
    .bus_wr_i    (bus_wr),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .head_i      (head),
    .head_vld_i  (head_vld),
    .flags_i     (flags),
    .bus_rdata_o (bus_rdata),
    .pop_o       (pop_req),
    .clr_o       (clr),
    .ien_o       (ien)
  );

  p_reset_quiet_r12: assert property (@(posedge clk)
    !rst_n |-> (!dma_req && !irq));

  p_dma_follows_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_mode && flags[FLG_AVAIL]) |-> dma_req);

endmodule

// File: tb/test_can_rxq.sv
module test_can_rxq;

  localparam int CLK_PERIOD = 10;

  localparam logic [1:0] OP_PUSH = 2'd0;
  localparam logic [1:0] OP_POP  = 2'd1;
  localparam logic [1:0] OP_FLAG = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  tag;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{OP_PUSH, 8'd1, 32'd0}, '{OP_PUSH, 8'd2, 32'd0}, '{OP_PUSH, 8'd3, 32'd0},
    '{OP_PUSH, 8'd4, 32'd0}, '{OP_PUSH, 8'd5, 32'd0},
    '{OP_FLAG, 8'd0, 32'd3},
    '{OP_PUSH, 8'd6, 32'd0},
    '{OP_FLAG, 8'd0, 32'd3},
    '{OP_PUSH, 8'd7, 32'd0},
    '{OP_FLAG, 8'd0, 32'd7},
    '{OP_POP, 8'd1, 32'd0}, '{OP_POP, 8'd2, 32'd0}, '{OP_POP, 8'd3, 32'd0},
    '{OP_POP, 8'd4, 32'd0}, '{OP_POP, 8'd5, 32'd0}, '{OP_POP, 8'd6, 32'd0},
    '{OP_FLAG, 8'd0, 32'd6}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dma_mode;
  logic        rx_valid;
  logic [31:0] rx_id, rx_ctrl, rx_data0, rx_data1;
  logic [8:0]  rx_hit;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        dma_req, irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  can_rxq i_can_rxq (
    .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode),
    .rx_valid(rx_valid), .rx_id(rx_id), .rx_ctrl(rx_ctrl),
    .rx_data0(rx_data0), .rx_data1(rx_data1), .rx_hit(rx_hit),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_req(dma_req), .irq(irq)
  );

  function automatic logic [31:0] f_id(input logic [7:0] t);
    return 32'h1800_0000 | {24'd0, t};
  endfunction
  function automatic logic [31:0] f_ctrl(input logic [7:0] t);
    return {8'hC0, t, 16'h0008};
  endfunction
  function automatic logic [31:0] f_d0(input logic [7:0] t);
    return {4{t}};
  endfunction
  function automatic logic [31:0] f_d1(input logic [7:0] t);
    return ~{4{t}};
  endfunction
  function automatic logic [31:0] f_hit(input logic [7:0] t);
    return {23'd0, 1'b1, t};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1;
    bus_addr = a;
    #1 d = bus_rdata;
    tick();
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1;
    bus_addr = a;
    bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic set_frame(input logic [7:0] t);
    rx_id = f_id(t);
    rx_ctrl = f_ctrl(t);
    rx_data0 = f_d0(t);
    rx_data1 = f_d1(t);
    rx_hit = f_hit(t)[8:0];
  endtask

  task automatic push(input logic [7:0] t);
    set_frame(t);
    rx_valid = 1'b1;
    tick();
    rx_valid = 1'b0;
  endtask

  task automatic push_and_pop(input logic [7:0] t, output logic [31:0] d);
    set_frame(t);
    rx_valid = 1'b1;
    bus_rd = 1'b1;
    bus_addr = 8'h8C;
    #1 d = bus_rdata;
    tick();
    rx_valid = 1'b0;
    bus_rd = 1'b0;
  endtask

  task automatic pop_check(input string req, input logic [7:0] t);
    logic [31:0] d;
    bus_read(8'h38, d); check(req, "attribute", d, f_hit(t));
    bus_read(8'h80, d); check(req, "window ctrl", d, f_ctrl(t));
    bus_read(8'h84, d); check(req, "window id", d, f_id(t));
    bus_read(8'h88, d); check(req, "window data0", d, f_d0(t));
    bus_read(8'h8C, d); check(req, "window data1", d, f_d1(t));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0;
    dma_mode = 1'b0;
    rx_valid = 1'b0;
    rx_id = '0; rx_ctrl = '0; rx_data0 = '0; rx_data1 = '0; rx_hit = '0;
    bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    check("R12", "dma_req after reset", {31'd0, dma_req}, 32'd0);
    check("R12", "irq after reset", {31'd0, irq}, 32'd0);
    bus_read(8'h30, d); check("R12", "flags after reset", d, 32'd0);
    bus_read(8'h34, d); check("R12", "enables after reset", d, 32'd0);
    bus_read(8'h84, d); check("R2", "empty window id", d, 32'd0);
    bus_read(8'h38, d); check("R2", "empty attribute", d, 32'd0);

    // table: fill past capacity in interrupt mode, then drain (R1 R2 R3 R6 R7)
    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_PUSH: begin
          push(VECS[i].tag);
          check("R4", "dma_req in interrupt mode", {31'd0, dma_req}, 32'd0);
          if (VECS[i].tag == 8'd1) begin
            bus_read(8'h30, d);
            check("R3", "available after first frame", d & 32'd1, 32'd1);
          end
        end
        OP_POP:  pop_check("R1 R2", VECS[i].tag);
        default: begin
          bus_read(8'h30, d);
          check("R6 R7", "flag register", d, VECS[i].exp);
        end
      endcase
      tick();
    end
    bus_read(8'h80, d); check("R1", "seventh frame discarded, window", d, 32'd0);
    bus_read(8'h8C, d); check("R2", "empty window data1", d, 32'd0);

    // R10 interrupt masking
    bus_write(8'h34, 32'd4);
    check("R10", "irq with overflow enabled", {31'd0, irq}, 32'd1);
    dma_mode = 1'b1;
    #1 check("R10", "irq forced low in DMA mode", {31'd0, irq}, 32'd0);
    dma_mode = 1'b0;
    bus_write(8'h34, 32'd0);
    check("R10", "irq with enables cleared", {31'd0, irq}, 32'd0);

    // R9 write-one-to-clear
    bus_write(8'h30, 32'd0);
    bus_read(8'h30, d); check("R9", "write zero keeps flags", d, 32'd6);
    bus_write(8'h30, 32'd2);
    bus_read(8'h30, d); check("R9", "clear warning", d, 32'd4);
    bus_write(8'h30, 32'd4);
    bus_read(8'h30, d); check("R9", "clear overflow", d, 32'd0);
    check("R6", "warning stays cleared while empty", d & 32'd2, 32'd0);

    // R9 interrupt-mode removal by writing one to the available bit
    push(8'd10);
    push(8'd11);
    bus_write(8'h30, 32'd1);
    bus_read(8'h84, d); check("R9", "write-one to available removes frame", d, f_id(8'd11));
    bus_write(8'h34, 32'd1);
    check("R10", "irq on enabled available", {31'd0, irq}, 32'd1);
    bus_write(8'h34, 32'd0);
    bus_read(8'h8C, d); check("R9", "remaining frame data1", d, f_d1(8'd11));
    tick();

    // R11 push and pop in one cycle while full
    for (int t = 20; t <= 25; t++) push(8'(t));
    push_and_pop(8'd26, d);
    check("R11", "popped oldest in shared cycle", d, f_d1(8'd20));
    tick();
    bus_read(8'h30, d); check("R11", "no overflow on shared cycle", d, 32'd3);
    for (int t = 21; t <= 26; t++) begin
      bus_read(8'h84, d); check("R11", "order after shared cycle", d, f_id(8'(t)));
      bus_read(8'h8C, d);
    end
    bus_write(8'h30, 32'd2);
    bus_read(8'h30, d); check("R6", "warning cleared after drain", d, 32'd0);

    // DMA mode
    dma_mode = 1'b1;
    #1 check("R4", "no request when empty", {31'd0, dma_req}, 32'd0);
    @(negedge clk);
    push(8'd30);
    check("R4", "request with frame in DMA mode", {31'd0, dma_req}, 32'd1);
    for (int t = 31; t <= 36; t++) push(8'(t));
    bus_read(8'h30, d); check("R8", "no warning or overflow in DMA mode", d, 32'd1);
    bus_write(8'h30, 32'd7);
    bus_read(8'h30, d); check("R9", "available not cleared by write in DMA", d, 32'd1);
    bus_read(8'h84, d); check("R9", "window unchanged by write in DMA", d, f_id(8'd30));
    bus_read(8'h8C, d); check("R5", "pop read data1", d, f_d1(8'd30));
    check("R5", "request low after pop", {31'd0, dma_req}, 32'd0);
    tick();
    check("R5", "request back with frames left", {31'd0, dma_req}, 32'd1);
    bus_read(8'h38, d); check("R5", "attribute of next frame", d, f_hit(8'd31));
    for (int t = 31; t <= 35; t++) begin
      bus_read(8'h8C, d); check("R5", "DMA pop order", d, f_d1(8'(t)));
      tick();
    end
    check("R5", "request stays low when drained", {31'd0, dma_req}, 32'd0);
    tick();
    check("R5", "request still low when drained", {31'd0, dma_req}, 32'd0);
    bus_read(8'h84, d); check("R1", "frame beyond six discarded in DMA", d, 32'd0);

    // R12 asynchronous reset between edges
    push(8'd40);
    check("R4", "request before reset", {31'd0, dma_req}, 32'd1);
    #2 rst_n = 1'b0;
    #1 check("R12", "request drops at reset", {31'd0, dma_req}, 32'd0);
    bus_rd = 1'b1;
    bus_addr = 8'h84;
    #1 check("R12", "queue emptied by reset", bus_rdata, 32'd0);
    bus_rd = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule